// File: doc/BRIEF.md
# Column Narrow-Cluster Encoder

This block sits behind the hit latches of one readout column of 128 binary pixel channels. On every bunch-crossing clock it takes a snapshot of all 128 hit bits and compresses it into a single 10-bit candidate word. A downstream correlator compares that word with the word from the paired sensor layer. The column is cut into 32 groups of 4 adjacent channels. The block looks for a group whose hits form only narrow clusters of one or two strips, which is what a high-momentum track leaves. Any hit that belongs to a run of three or more adjacent channels is treated as a wide cluster, and the group it touches is discarded. This holds even when the run crosses from one group into the next.

The candidate word carries the group index, the 4-bit hit shape inside the group, and a flag bit. The flag marks a candidate that touches the top channel of the column, where the chip boundary leaves no neighbour on the far side. If several groups qualify in the same crossing, the lowest-indexed one is sent and a separate flag reports that others were dropped. The result appears one clock after the hits are sampled.

Top module: `column_cluster_encoder`

## Requirements
- R1: Group g covers channels 4g to 4g+3, and bit i of a group pattern is channel 4g+i. The reported pattern equals the hit bits of the reported group, sampled in the crossing that produced the word.
- R2: The word is laid out with the group index in bits [9:5], the 4-bit pattern in bits [4:1] and the flag in bit 0.
- R3: A nonzero group pattern with no three adjacent hits qualifies as a candidate. Examples are 4'b0001, 4'b0110, 4'b0101, 4'b1011 and 4'b1101.
- R4: A group whose own pattern holds three or more adjacent hits (4'b0111, 4'b1110, 4'b1111) never qualifies. An empty group never qualifies.
- R5: A run of three or more adjacent hit channels that crosses a group boundary disqualifies every group it touches. An example is channels 7, 8 and 9, which disqualifies groups 1 and 2.
- R6: Nothing exists above channel 127. The flag bit is 1 exactly when the reported group is 31 and channel 127 is hit.
- R7: When several groups qualify in one crossing, the lowest group index is reported. Disqualified groups take no part in this choice.
- R8: The overflow output is 1 exactly when two or more groups qualify in the same crossing, and it is only ever 1 together with valid.
- R9: Valid is 1 in the clock after each crossing that has a candidate, and 0 after each crossing that has none. Whenever valid is 0, the word and the overflow output are 0.
- R10: A synchronous active-high reset clears valid, the word and the overflow output at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| hits_i | input | 128 | Latched hit bits of the column, bit c is channel c |
| cand_valid_o | output | 1 | A candidate word is present this cycle |
| cand_word_o | output | 10 | Group index, pattern and edge flag |
| cand_multi_o | output | 1 | More than one group qualified in that crossing |

## Verification
On every cycle the assertions check the following:
- the reported pattern matches the sampled hits of the reported group;
- a reported pattern is never empty;
- the overflow output and the edge flag appear only where they are allowed;
- idle cycles and reset leave the outputs at zero.

Several behaviours can only be shown by the bench's scenarios, which compare each output against a reference model of the requirements:
- rejection of wide runs, both inside a group and across group boundaries;
- the lowest-index choice;
- whether a candidate was missed altogether.

Directed vectors cover the boundary at channel 127. They also cover runs that cross a group boundary, and mixes of disqualified and qualifying groups. Random columns at several hit densities cover the general case.

// File: rtl/colenc_pkg.sv
package colenc_pkg;

    localparam int DEF_CHANNELS = 128;
    localparam int DEF_GROUP    = 4;
    localparam int DEF_MIN_WIDE = 3;

    typedef enum logic [1:0] {
        GRP_EMPTY  = 2'd0,
        GRP_NARROW = 2'd1,
        GRP_WIDE   = 2'd2
    } grp_class_e;

    function automatic logic class_qualifies(input grp_class_e c);
        return (c == GRP_NARROW);
    endfunction

endpackage

// File: rtl/colenc_wide_mask.sv
module colenc_wide_mask
    import colenc_pkg::*;
#(
    parameter int CHANNELS = DEF_CHANNELS,
    parameter int MIN_WIDE = DEF_MIN_WIDE
) (
    input  logic [CHANNELS-1:0] hits_i,
    output logic [CHANNELS-1:0] wide_o
);
    localparam int N_START = CHANNELS - MIN_WIDE + 1;

    logic [N_START-1:0] run_start;

    // a run of MIN_WIDE hits begins at channel s
    for (genvar s = 0; s < N_START; s++) begin : g_start
        assign run_start[s] = &hits_i[s +: MIN_WIDE];
    end

    // channel c is wide if any qualifying run covers it
    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        always_comb begin
            wide_o[c] = 1'b0;
            for (int k = 0; k < MIN_WIDE; k++) begin
                if ((c - k) >= 0 && (c - k) < N_START) begin
                    wide_o[c] = wide_o[c] | run_start[c - k];
                end
            end
        end
    end

endmodule

// File: rtl/colenc_group_class.sv
module colenc_group_class
    import colenc_pkg::*;
#(
    parameter int GROUP = DEF_GROUP
) (
    input  logic [GROUP-1:0] pat_i,
    input  logic [GROUP-1:0] wide_i,
    output grp_class_e       cls_o
);
    always_comb begin
        if (pat_i == '0) begin
            cls_o = GRP_EMPTY;
        end else if (|wide_i) begin
            cls_o = GRP_WIDE;
        end else begin
            cls_o = GRP_NARROW;
        end
    end

endmodule

// File: rtl/colenc_select.sv
module colenc_select #(
    parameter int GROUPS = 32,
    localparam int ADDR_W = $clog2(GROUPS)
) (
    input  logic [GROUPS-1:0] qual_i,
    output logic              found_o,
    output logic [ADDR_W-1:0] idx_o,
    output logic              multi_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        multi_o = 1'b0;
        for (int g = 0; g < GROUPS; g++) begin
            if (qual_i[g]) begin
                if (found_o) begin
                    multi_o = 1'b1;
                end else begin
                    found_o = 1'b1;
                    idx_o   = ADDR_W'(g);
                end
            end
        end
    end

endmodule

// File: rtl/column_cluster_encoder.sv
module column_cluster_encoder
    import colenc_pkg::*;
#(
    parameter int CHANNELS = DEF_CHANNELS,
    parameter int GROUP    = DEF_GROUP,
    parameter int MIN_WIDE = DEF_MIN_WIDE,
    localparam int GROUPS  = CHANNELS / GROUP,
    localparam int ADDR_W  = $clog2(GROUPS),
    localparam int WORD_W  = ADDR_W + GROUP + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CHANNELS-1:0] hits_i,
    output logic                cand_valid_o,
    output logic [WORD_W-1:0]   cand_word_o,
    output logic                cand_multi_o
);
    logic [CHANNELS-1:0] wide;
    grp_class_e          cls [GROUPS];
    logic [GROUPS-1:0]   qual;
    logic                found;
    logic [ADDR_W-1:0]   idx;
    logic                multi;
    logic [GROUP-1:0]    win_pat;
    logic                edge_flag;
    logic [WORD_W-1:0]   word_d;

    colenc_wide_mask #(
        .CHANNELS (CHANNELS),
        .MIN_WIDE (MIN_WIDE)
    ) u_wide (
        .hits_i (hits_i),
        .wide_o (wide)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        colenc_group_class #(
            .GROUP (GROUP)
        ) u_cls (
            .pat_i  (hits_i[g*GROUP +: GROUP]),
            .wide_i (wide[g*GROUP +: GROUP]),
            .cls_o  (cls[g])
        );
        assign qual[g] = class_qualifies(cls[g]);
    end

    colenc_select #(
        .GROUPS (GROUPS)
    ) u_sel (
        .qual_i  (qual),
        .found_o (found),
        .idx_o   (idx),
        .multi_o (multi)
    );

    always_comb begin
        win_pat = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (idx == ADDR_W'(g)) begin
                win_pat = hits_i[g*GROUP +: GROUP];
            end
        end
    end

    assign edge_flag = (idx == ADDR_W'(GROUPS - 1)) && win_pat[GROUP-1];
    assign word_d    = found ? {idx, win_pat, edge_flag} : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_valid_o <= 1'b0;
            cand_word_o  <= '0;
            cand_multi_o <= 1'b0;
        end else begin
            cand_valid_o <= found;
            cand_word_o  <= word_d;
            cand_multi_o <= found & multi;
        end
    end

endmodule

// File: rtl/column_cluster_encoder_chk.sv
module column_cluster_encoder_chk #(
    parameter int CHANNELS = 128,
    parameter int GROUP    = 4,
    localparam int GROUPS  = CHANNELS / GROUP,
    localparam int ADDR_W  = $clog2(GROUPS),
    localparam int WORD_W  = ADDR_W + GROUP + 1
) (
    input logic                clk,
    input logic                rst,
    input logic [CHANNELS-1:0] hits_i,
    input logic                cand_valid_o,
    input logic [WORD_W-1:0]   cand_word_o,
    input logic                cand_multi_o
);
    logic [CHANNELS-1:0] hits_q;
    logic [ADDR_W-1:0]   w_addr;
    logic [GROUP-1:0]    w_pat;
    logic                w_flag;

    always_ff @(posedge clk) hits_q <= hits_i;

    assign w_addr = cand_word_o[WORD_W-1 -: ADDR_W];
    assign w_pat  = cand_word_o[GROUP:1];
    assign w_flag = cand_word_o[0];

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!cand_valid_o && cand_word_o == '0 && !cand_multi_o));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !cand_valid_o |-> (cand_word_o == '0 && !cand_multi_o));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        cand_multi_o |-> cand_valid_o);

    assert_pattern_source_R1: assert property (@(posedge clk) disable iff (rst)
        cand_valid_o |-> (w_pat == hits_q[int'(w_addr)*GROUP +: GROUP]));

    assert_pattern_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        cand_valid_o |-> (w_pat != '0));

    assert_edge_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (cand_valid_o && w_flag) |-> (w_addr == ADDR_W'(GROUPS - 1) && w_pat[GROUP-1]));

endmodule

bind column_cluster_encoder column_cluster_encoder_chk #(
    .CHANNELS (CHANNELS),
    .GROUP    (GROUP)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .hits_i       (hits_i),
    .cand_valid_o (cand_valid_o),
    .cand_word_o  (cand_word_o),
    .cand_multi_o (cand_multi_o)
);

// File: tb/column_cluster_encoder_bench.sv
module column_cluster_encoder_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] hits_i = '0;
    logic         cand_valid_o;
    logic [9:0]   cand_word_o;
    logic         cand_multi_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    column_cluster_encoder u_column_cluster_encoder (
        .clk          (clk),
        .rst          (rst),
        .hits_i       (hits_i),
        .cand_valid_o (cand_valid_o),
        .cand_word_o  (cand_word_o),
        .cand_multi_o (cand_multi_o)
    );

    always #2 clk = ~clk;

    // expected {multi, valid, word[9:0]} from the requirements
    function automatic logic [11:0] model(input logic [127:0] h);
        logic [127:0] wide;
        int run;
        int first;
        int count;
        logic [3:0] pat;
        logic [3:0] fpat;
        wide  = '0;
        run   = 0;
        first = -1;
        count = 0;
        fpat  = '0;
        for (int c = 0; c <= 128; c++) begin
            if (c < 128 && h[c]) begin
                run++;
            end else begin
                if (run >= 3) begin
                    for (int k = c - run; k < c; k++) wide[k] = 1'b1;
                end
                run = 0;
            end
        end
        for (int g = 0; g < 32; g++) begin
            pat = h[g*4 +: 4];
            if (pat != 4'b0 && wide[g*4 +: 4] == 4'b0) begin
                count++;
                if (first < 0) begin
                    first = g;
                    fpat  = pat;
                end
            end
        end
        if (first < 0) return 12'b0;
        return {count > 1, 1'b1, 5'(first), fpat, (first == 31) && fpat[3]};
    endfunction

    task automatic check_out(input logic [11:0] exp, input string tag);
        logic [11:0] act;
        act = {cand_multi_o, cand_valid_o, cand_word_o};
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual multi=%0b valid=%0b word=%b expected multi=%0b valid=%0b word=%b",
                     tag, act[11], act[10], act[9:0], exp[11], exp[10], exp[9:0]);
        end
    endtask

    task automatic apply(input logic [127:0] h, input string tag);
        @(negedge clk);
        hits_i = h;
        @(negedge clk);
        check_out(model(h), tag);
    endtask

    function automatic logic [127:0] ch(input int a, input int b, input int c);
        logic [127:0] v;
        v = '0;
        if (a >= 0) v[a] = 1'b1;
        if (b >= 0) v[b] = 1'b1;
        if (c >= 0) v[c] = 1'b1;
        return v;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] h;
        int dens;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_out(12'b0, "R10 reset state");
        rst = 1'b0;

        // R1 R2: channel 9 -> group 2, bit 1
        apply(ch(9, -1, -1), "R1 R2 single hit");
        check_out({2'b01, 5'd2, 4'b0010, 1'b0}, "R2 word layout");
        // R3: double cluster 1011 in group 5
        apply(ch(20, 21, 23), "R3 pattern 1011");
        apply(ch(20, 22, -1), "R3 pattern 0101");
        // R4: wide inside group
        apply(ch(12, 13, 14), "R4 pattern 0111");
        apply(ch(12, 13, 14) | ch(15, -1, -1), "R4 pattern 1111");
        apply('0, "R4 R9 empty column");
        // R5: run across boundary of groups 1 and 2
        apply(ch(7, 8, 9), "R5 cross boundary run");
        apply(ch(7, 8, -1), "R5 R8 two-strip across boundary");
        check_out({2'b11, 5'd1, 4'b1000, 1'b0}, "R7 R8 boundary pair");
        // R6: upper edge
        apply(ch(127, -1, -1), "R6 channel 127");
        check_out({2'b01, 5'd31, 4'b1000, 1'b1}, "R6 edge flag");
        apply(ch(126, 127, -1), "R6 channels 126 127");
        apply(ch(125, 126, 127), "R6 wide at edge");
        apply(ch(124, -1, -1), "R6 channel 124 no flag");
        // R7 R8: priority
        apply(ch(16, 81, -1), "R7 R8 groups 4 and 20");
        apply(ch(12, 13, 14) | ch(41, -1, -1), "R7 wide group 3 skipped");
        check_out({2'b01, 5'd10, 4'b0010, 1'b0}, "R7 R8 wide not counted");
        // R9: candidate then none
        apply(ch(50, -1, -1), "R9 candidate");
        apply('0, "R9 drop after candidate");
        // R10: reset mid run
        @(negedge clk);
        hits_i = ch(33, -1, -1);
        rst = 1'b1;
        @(negedge clk);
        check_out(12'b0, "R10 reset clears");
        rst = 1'b0;
        apply(ch(33, -1, -1), "R10 resume after reset");

        // random columns at several densities
        for (int i = 0; i < 600; i++) begin
            case (i % 4)
                0: dens = 1;
                1: dens = 3;
                2: dens = 8;
                default: dens = 35;
            endcase
            for (int c = 0; c < 128; c++) h[c] = (($urandom % 100) < dens);
            apply(h, "R3 R4 R5 R7 R8 random");
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule